// File: doc/BRIEF.md
# Transmit Metaframe Builder with Per-Frame Burst Gating

This block produces the transmit word stream of a framing layer that groups words into fixed-length metaframes. Each metaframe opens with a synchronisation control word, continues with a scrambler-state control word and a skip control word, carries a run of payload slots, and closes with a diagnostic control word. Every output word comes with a flag that marks it as a control word or a data word. A pulse marks the first word of each metaframe.

A burst-enable input is sampled once, in the cycle that builds the first word of a metaframe. That sampled value governs every payload slot of the metaframe. When it is low, the FIFO is not touched and every payload slot carries a skip word. When it is high, payload slots are filled from a show-ahead transmit FIFO through a read strobe. A slot whose FIFO is empty gets a skip word; the stream never stalls. The diagnostic word carries a two-bit health field, with lane health in bit 33 and link health in bit 32, taken from two status inputs.

Scrambling, CRC generation and lane striping sit outside this block. Every word goes through one output register, so a word appears one clock after the cycle that builds it.

Top module: `mframeTx`

## Requirements
- R1: While reset is asserted and right after its release, `txWord` is 0, `txCtrl` is 0, `frameStart` is 0 and `fifoRd` is 0. The first metaframe starts at its sync word on the first clock after release.
- R2: Word slots are numbered 0 to FRAME_LEN-1, and the sequence repeats every FRAME_LEN words. Slot 0 carries the sync word 64'hA5C3_0F1E_A5C3_0F1E. Slot 1 carries the scrambler-state word, which is 64'h2800_0000_0000_0000 OR SCRAM_SEED. Slot 2 carries the skip word 64'h1E00_0000_0000_0000. Slots 3 to FRAME_LEN-2 are payload slots. Slot FRAME_LEN-1 is the diagnostic word. Every word except a FIFO data word has `txCtrl`=1.
- R3: `frameStart` is high for exactly one cycle, together with each sync word, and is low at all other times.
- R4: `burstEn` is sampled only in the cycle that builds slot 0. Changes on `burstEn` in any other slot have no effect on `fifoRd` or on the output words.
- R5: When the sampled burst enable is 0, `fifoRd` stays low for the whole metaframe, and every payload slot carries the skip word with `txCtrl`=1.
- R6: When the sampled burst enable is 1 and `fifoEmpty` is 0 in a payload-slot cycle, `fifoRd` is high in that cycle. On the next clock, `txWord` equals the `fifoData` value of that cycle, with `txCtrl`=0.
- R7: When the sampled burst enable is 1 but `fifoEmpty` is 1 in a payload-slot cycle, `fifoRd` stays low and the slot carries the skip word with `txCtrl`=1.
- R8: The diagnostic word is 64'h6400_0000_0000_0000 with bit 33 = `laneOk` and bit 32 = `linkOk`. Both are sampled in the cycle that builds the word.
- R9: `fifoRd` is never high while `fifoEmpty` is high, and never high outside payload slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| burstEn | input | 1 | Payload source select, sampled at the start of each metaframe |
| laneOk | input | 1 | Lane health, placed in diagnostic bit 33 |
| linkOk | input | 1 | Link health, placed in diagnostic bit 32 |
| fifoData | input | DATA_W | Head word of the show-ahead transmit FIFO |
| fifoEmpty | input | 1 | FIFO holds no word |
| fifoRd | output | 1 | Pops the FIFO head at the clock edge |
| txWord | output | DATA_W | Registered output word |
| txCtrl | output | 1 | 1 = control word, 0 = data word |
| frameStart | output | 1 | Pulse with the first word of a metaframe |

## Verification
A slot counter that has drifted shows within one metaframe. `frameStart` then lands at the wrong spacing, and a control word appears in the wrong slot. A stale or wrongly timed burst latch shows as a read strobe, or a missing one, in the very first payload slot after the sync word. The bench compares the stream against a reference model on every clock, so the first wrong cycle is reported. A status bit routed to the wrong place shows on the next diagnostic word.

// File: rtl/mframeTxPkg.sv
package mframeTxPkg;

  localparam int WORD_W = 64;

  localparam logic [WORD_W-1:0] SYNC_PAT  = 64'hA5C3_0F1E_A5C3_0F1E;
  localparam logic [WORD_W-1:0] SCRAM_TAG = 64'h2800_0000_0000_0000;
  localparam logic [WORD_W-1:0] SKIP_PAT  = 64'h1E00_0000_0000_0000;
  localparam logic [WORD_W-1:0] DIAG_TAG  = 64'h6400_0000_0000_0000;

  localparam int LANE_BIT = 33;
  localparam int LINK_BIT = 32;

  // One-hot word-select strobes from control to datapath
  typedef struct packed {
    logic first;
    logic sync;
    logic scram;
    logic skip;
    logic data;
    logic diag;
  } strobeT;

endpackage

// File: rtl/mframeTxCtrl.sv
module mframeTxCtrl
  import mframeTxPkg::*;
#(
  parameter int FRAME_LEN = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   burstEn,
  input  logic   fifoEmpty,
  output logic   fifoRd,
  output strobeT strobe
);

  localparam int POS_W    = (FRAME_LEN > 2) ? $clog2(FRAME_LEN) : 1;
  localparam int LAST_POS = FRAME_LEN - 1;
  localparam int PAY_LO   = 3;
  localparam int PAY_HI   = FRAME_LEN - 2;

  logic [POS_W-1:0] pos;
  logic             burstReg;
  logic             atFirst;
  logic             atLast;
  logic             inPayload;

  assign atFirst   = (pos == '0);
  assign atLast    = (pos == POS_W'(LAST_POS));
  assign inPayload = (pos >= POS_W'(PAY_LO)) && (pos <= POS_W'(PAY_HI));

  // Slot counter: wraps after the diagnostic slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
    end else if (atLast) begin
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  // Burst decision captured once per metaframe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstReg <= 1'b0;
    end else if (atFirst) begin
      burstReg <= burstEn;
    end
  end

  assign fifoRd = inPayload && burstReg && !fifoEmpty;

  always_comb begin
    strobe       = '0;
    strobe.first = atFirst;
    strobe.sync  = atFirst;
    strobe.scram = (pos == POS_W'(1));
    strobe.diag  = atLast;
    strobe.data  = fifoRd;
    strobe.skip  = (pos == POS_W'(2)) || (inPayload && !fifoRd);
  end

endmodule

// File: rtl/mframeTxDp.sv
module mframeTxDp
  import mframeTxPkg::*;
#(
  parameter int          DATA_W     = WORD_W,
  parameter logic [55:0] SCRAM_SEED = 56'h5A_F00D_C0DE_1234
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              laneOk,
  input  logic              linkOk,
  output logic [DATA_W-1:0] txWord,
  output logic              txCtrl,
  output logic              frameStart
);

  localparam logic [DATA_W-1:0] SYNC_W  = DATA_W'(SYNC_PAT);
  localparam logic [DATA_W-1:0] SCRAM_W = DATA_W'(SCRAM_TAG) | DATA_W'(SCRAM_SEED);
  localparam logic [DATA_W-1:0] SKIP_W  = DATA_W'(SKIP_PAT);
  localparam logic [DATA_W-1:0] DIAG_W  = DATA_W'(DIAG_TAG);

  logic [DATA_W-1:0] nextWord;
  logic              nextCtrl;
  logic [DATA_W-1:0] diagWord;

  always_comb begin
    diagWord           = DIAG_W;
    diagWord[LANE_BIT] = laneOk;
    diagWord[LINK_BIT] = linkOk;
  end

  always_comb begin
    nextWord = SKIP_W;
    nextCtrl = 1'b1;
    unique case (1'b1)
      strobe.sync:  nextWord = SYNC_W;
      strobe.scram: nextWord = SCRAM_W;
      strobe.diag:  nextWord = diagWord;
      strobe.data: begin
        nextWord = fifoData;
        nextCtrl = 1'b0;
      end
      default:      nextWord = SKIP_W;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord     <= '0;
      txCtrl     <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      txWord     <= nextWord;
      txCtrl     <= nextCtrl;
      frameStart <= strobe.first;
    end
  end

endmodule

// File: rtl/mframeTx.sv
module mframeTx
  import mframeTxPkg::*;
#(
  parameter int          DATA_W     = WORD_W,
  parameter int          FRAME_LEN  = 8,
  parameter logic [55:0] SCRAM_SEED = 56'h5A_F00D_C0DE_1234
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              burstEn,
  input  logic              laneOk,
  input  logic              linkOk,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoRd,
  output logic [DATA_W-1:0] txWord,
  output logic              txCtrl,
  output logic              frameStart
);

  strobeT strobe;

  mframeTxCtrl #(
    .FRAME_LEN(FRAME_LEN)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .burstEn  (burstEn),
    .fifoEmpty(fifoEmpty),
    .fifoRd   (fifoRd),
    .strobe   (strobe)
  );

  mframeTxDp #(
    .DATA_W    (DATA_W),
    .SCRAM_SEED(SCRAM_SEED)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fifoData  (fifoData),
    .laneOk    (laneOk),
    .linkOk    (linkOk),
    .txWord    (txWord),
    .txCtrl    (txCtrl),
    .frameStart(frameStart)
  );

endmodule

// File: rtl/mframeTxChk.sv
module mframeTxChk
  import mframeTxPkg::*;
#(
  parameter int DATA_W    = WORD_W,
  parameter int FRAME_LEN = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              laneOk,
  input logic              linkOk,
  input logic [DATA_W-1:0] fifoData,
  input logic              fifoEmpty,
  input logic              fifoRd,
  input logic [DATA_W-1:0] txWord,
  input logic              txCtrl,
  input logic              frameStart
);

  localparam int GAP_W = $clog2(FRAME_LEN + 2);

  logic [GAP_W-1:0] gap;
  logic             seenStart;

  // Cycles since the last frameStart, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap       <= '0;
      seenStart <= 1'b0;
    end else if (frameStart) begin
      gap       <= GAP_W'(1);
      seenStart <= 1'b1;
    end else if (gap != GAP_W'(FRAME_LEN + 1)) begin
      gap <= gap + 1'b1;
    end
  end

  AST_RD_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> !fifoEmpty);                                           // R9

  AST_RD_FORWARDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> (!txCtrl && txWord == $past(fifoData)));               // R6

  AST_START_IS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (txCtrl && txWord == DATA_W'(SYNC_PAT)));          // R3

  AST_START_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && seenStart) |-> (gap == GAP_W'(FRAME_LEN)));         // R2

  AST_NO_RD_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !fifoRd);                                          // R9

  AST_DIAG_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (seenStart && txCtrl && txWord[DATA_W-1 -: 8] == DIAG_TAG[WORD_W-1 -: 8])
      |-> (txWord[LANE_BIT] == $past(laneOk) && txWord[LINK_BIT] == $past(linkOk))); // R8

endmodule

bind mframeTx mframeTxChk #(
  .DATA_W   (DATA_W),
  .FRAME_LEN(FRAME_LEN)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .laneOk    (laneOk),
  .linkOk    (linkOk),
  .fifoData  (fifoData),
  .fifoEmpty (fifoEmpty),
  .fifoRd    (fifoRd),
  .txWord    (txWord),
  .txCtrl    (txCtrl),
  .frameStart(frameStart)
);

// File: tb/tb_mframeTx.sv
module tb_mframeTx;
  import mframeTxPkg::*;

  localparam int DW = 64;
  localparam int FL = 8;
  localparam logic [55:0] SEED = 56'h5A_F00D_C0DE_1234;
  localparam logic [DW-1:0] SCRAM_EXP = SCRAM_TAG | {8'h00, SEED};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          burstEn = 1'b0;
  logic          laneOk = 1'b0;
  logic          linkOk = 1'b0;
  logic [DW-1:0] fifoData = '0;
  logic          fifoEmpty = 1'b1;
  logic          fifoRd;
  logic [DW-1:0] txWord;
  logic          txCtrl;
  logic          frameStart;

  mframeTx #(.DATA_W(DW), .FRAME_LEN(FL), .SCRAM_SEED(SEED)) dut (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .laneOk(laneOk), .linkOk(linkOk),
    .fifoData(fifoData), .fifoEmpty(fifoEmpty), .fifoRd(fifoRd),
    .txWord(txWord), .txCtrl(txCtrl), .frameStart(frameStart)
  );

  always #5 clk = ~clk;

  int            nChecks = 0;
  int            nFails  = 0;
  logic [DW-1:0] fq[$];
  logic [DW-1:0] nextFill = 64'h0000_0001_0000_0000;
  int            mPos   = 0;
  bit            mBurst = 1'b0;
  logic [DW-1:0] expWord = '0;
  bit            expCtrl = 1'b0;
  bit            expStart = 1'b0;
  string         expTag = "R1";

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic refill(input int n);
    for (int i = 0; i < n; i++) begin
      fq.push_back(nextFill);
      nextFill = nextFill + 64'h1_0000_0003;
    end
  endtask

  // One clock of stimulus plus model update; called just after a falling edge
  task automatic step(input bit burst, input bit lane, input bit link,
                      input bit forceEmpty, input string phaseTag);
    bit payload;
    bit expRd;
    chk(txWord == expWord, expTag, txWord, expWord);
    chk(txCtrl == expCtrl, expTag, {63'd0, txCtrl}, {63'd0, expCtrl});
    chk(frameStart == expStart, "R3", {63'd0, frameStart}, {63'd0, expStart});

    burstEn   = burst;
    laneOk    = lane;
    linkOk    = link;
    fifoEmpty = forceEmpty || (fq.size() == 0);
    fifoData  = (fq.size() != 0) ? fq[0] : '0;
    #1;
    payload = (mPos >= 3) && (mPos <= FL - 2);
    expRd   = payload && mBurst && !fifoEmpty;
    chk(fifoRd == expRd, "R9", {63'd0, fifoRd}, {63'd0, expRd});

    expStart = (mPos == 0);
    expCtrl  = 1'b1;
    if (mPos == 0) begin
      expWord = SYNC_PAT; expTag = "R2";
    end else if (mPos == 1) begin
      expWord = SCRAM_EXP; expTag = "R2";
    end else if (mPos == 2) begin
      expWord = SKIP_PAT; expTag = "R2";
    end else if (mPos == FL - 1) begin
      expWord = DIAG_TAG;
      expWord[LANE_BIT] = lane;
      expWord[LINK_BIT] = link;
      expTag = "R8";
    end else if (expRd) begin
      expWord = fifoData; expCtrl = 1'b0; expTag = phaseTag.len() ? phaseTag : "R6";
    end else begin
      expWord = SKIP_PAT;
      expTag = !mBurst ? "R5" : "R7";
    end

    if (mPos == 0) mBurst = burst;
    if (expRd) void'(fq.pop_front());
    mPos = (mPos + 1) % FL;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(txWord == '0, "R1", txWord, '0);
    chk(!txCtrl && !frameStart, "R1", {62'd0, txCtrl, frameStart}, '0);
    chk(!fifoRd, "R1", {63'd0, fifoRd}, '0);
    rstN = 1'b1;
    refill(400);

    // Burst on, FIFO always ready: R6
    for (int i = 0; i < 10 * FL; i++) step(1'b1, i[0], i[1], 1'b0, "R6");
    // Burst off: R5
    for (int i = 0; i < 10 * FL; i++) step(1'b0, 1'b1, 1'b0, 1'b0, "");
    // Burst toggling every cycle: only the slot-0 sample counts, R4
    for (int i = 0; i < 20 * FL; i++) step(1'($urandom), 1'($urandom), 1'($urandom), 1'b0, "R4");
    // Burst on with random empty slots: R7
    for (int i = 0; i < 20 * FL; i++) step(1'b1, 1'b0, 1'b1, 1'(($urandom % 3) == 0), "R7");
    // Everything random, including a FIFO that runs dry
    for (int i = 0; i < 60 * FL; i++) step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule